// File: doc/BRIEF.md
# Parallel Printer Strobe Sequencer

This block drives a parallel printer port from bytes that a processor writes one at a time. A write captures the byte onto the printer data lines. The block then waits a fixed setup time of about 2 microseconds and issues an active-low strobe lasting about 1 microsecond. After that it holds the port busy until the printer returns an acknowledge. Only that acknowledge lets the next byte in.

Both times are counted in system clocks. They are derived from a clock-frequency parameter and rounded up to whole cycles. A status byte combines the printer's fault, select, paper-out and busy lines with the port's ready flag, so that a processor can poll one location. The auto-feed and select-input printer signals are not driven.

Top module: `lpt_strobe_seq`

## Requirements
- R1: After reset, strobe_no is 1, ready_o is 1 and pdata_o is 8'h00.
- R2: A write (wr_i high at a clock edge) while ready_o is 1 is accepted. After that edge, pdata_o equals the written byte and ready_o is 0.
- R3: The strobe goes low at the clock edge that comes SETUP_CYC edges after the accepting edge. SETUP_CYC = ceil(CLK_FREQ_HZ × SETUP_NS / 1e9), and SETUP_NS defaults to 2000.
- R4: The strobe stays low for exactly WIDTH_CYC cycles and then returns high. WIDTH_CYC = ceil(CLK_FREQ_HZ × WIDTH_NS / 1e9), and WIDTH_NS defaults to 1000.
- R5: pdata_o holds the accepted byte without change from the accepting edge through the strobe and until the port is ready again.
- R6: Once the strobe has ended, ready_o stays 0 until ack_i is sampled high. ready_o is 1 after the first edge at which ack_i is high.
- R7: ack_i has no effect while the setup delay or the strobe is still in progress: the timing continues and ready_o stays 0.
- R8: A write while ready_o is 0 is ignored: pdata_o keeps the previous byte and the strobe timing is unchanged.
- R9: status_o packs the lines as follows: bit 7 = fault_i, bit 6 = select_i, bit 5 = paper_out_i, bit 4 = busy_i, bit 3 = ready_o (1 means ready), and bits 2..0 = 0.
- R10: strobe_no is never low while ready_o is 1, and each accepted write gives exactly one strobe pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Data register write strobe |
| wdata_i | input | 8 | Byte to print |
| ack_i | input | 1 | Printer acknowledge, active high, synchronous |
| busy_i | input | 1 | Printer busy line |
| paper_out_i | input | 1 | Printer out-of-paper line |
| fault_i | input | 1 | Printer fault line |
| select_i | input | 1 | Printer selected line |
| pdata_o | output | 8 | Printer data lines |
| strobe_no | output | 1 | Data strobe, active low |
| ready_o | output | 1 | Port can take a new byte |
| status_o | output | 8 | Packed status byte |

## Verification
A wrong sequencer state or counter value appears on the strobe pin within one setup-plus-width window of a write. The strobe edge comes early or late, or its width differs, and the bench checks strobe_no against the computed edge cycles on every clock of every transfer. A lost or spurious return to idle shows on ready_o and on status bit 3 in the same cycle. A corrupted data register shows on pdata_o, which is compared on every cycle of a transfer. The bench sweeps all 256 byte values, injects early acknowledges and refused writes, and sweeps all 16 status line patterns in both the idle and busy states.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_WAIT   = 2'd3
  } lpt_state_e;

  // ceil(hz * ns / 1e9), at least one cycle
  function automatic int ns_to_cycles(longint hz, longint ns);
    longint c;
    c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/lpt_cycle_timer.sv
module lpt_cycle_timer #(
  parameter int CNT_W   = 8,
  parameter int MAX_VAL = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= MAX_VAL); // R3

endmodule

// File: rtl/lpt_seq_fsm.sv
module lpt_seq_fsm
  import lpt_pkg::*;
#(
  parameter int               CNT_W    = 8,
  parameter logic [CNT_W-1:0] SETUP_LD = '0,
  parameter logic [CNT_W-1:0] WIDTH_LD = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             ack_i,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             ready_o,
  output logic             strobe_no
);

  lpt_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = SETUP_LD;
    accept_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (wr_i) begin
        accept_o = 1'b1;
        load_o   = 1'b1;
        state_d  = ST_SETUP;
      end
      ST_SETUP: if (zero_i) begin
        load_o     = 1'b1;
        load_val_o = WIDTH_LD;
        state_d    = ST_STROBE;
      end
      ST_STROBE: if (zero_i) state_d = ST_WAIT;
      ST_WAIT:   if (ack_i)  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign strobe_no = (state_q != ST_STROBE);

  AST_STB_FROM_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_STROBE) |-> $past(state_q) == ST_SETUP); // R3

  AST_STB_ENDS_IN_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(state_q == ST_STROBE) |-> state_q == ST_WAIT); // R4

  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !ack_i) |=> state_q == ST_WAIT); // R6

  AST_ACK_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && ack_i) |=> state_q == ST_IDLE); // R6

  AST_ACK_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP || state_q == ST_STROBE) |=> state_q != ST_IDLE); // R7

endmodule

// File: rtl/lpt_status_pack.sv
module lpt_status_pack (
  input  logic       fault_i,
  input  logic       select_i,
  input  logic       paper_out_i,
  input  logic       busy_i,
  input  logic       ready_i,
  output logic [7:0] status_o
);

  localparam int FAULT_BIT = 7;
  localparam int SEL_BIT   = 6;
  localparam int PAPER_BIT = 5;
  localparam int BUSY_BIT  = 4;
  localparam int READY_BIT = 3;

  always_comb begin
    status_o            = '0;
    status_o[FAULT_BIT] = fault_i;
    status_o[SEL_BIT]   = select_i;
    status_o[PAPER_BIT] = paper_out_i;
    status_o[BUSY_BIT]  = busy_i;
    status_o[READY_BIT] = ready_i;
  end

endmodule

// File: rtl/lpt_strobe_seq.sv
module lpt_strobe_seq
  import lpt_pkg::*;
#(
  parameter longint CLK_FREQ_HZ = 50_000_000,
  parameter longint SETUP_NS    = 2000,
  parameter longint WIDTH_NS    = 1000,
  parameter int     DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  input  logic              busy_i,
  input  logic              paper_out_i,
  input  logic              fault_i,
  input  logic              select_i,
  output logic [DATA_W-1:0] pdata_o,
  output logic              strobe_no,
  output logic              ready_o,
  output logic [7:0]        status_o
);

  localparam int SETUP_CYC = ns_to_cycles(CLK_FREQ_HZ, SETUP_NS);
  localparam int WIDTH_CYC = ns_to_cycles(CLK_FREQ_HZ, WIDTH_NS);
  localparam int MAX_CYC   = (SETUP_CYC > WIDTH_CYC) ? SETUP_CYC : WIDTH_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] WIDTH_LD = CNT_W'(WIDTH_CYC - 1);

  logic             tmr_load, tmr_zero, accept;
  logic [CNT_W-1:0] tmr_val;
  logic [DATA_W-1:0] data_q;

  lpt_cycle_timer #(.CNT_W(CNT_W), .MAX_VAL(MAX_CYC - 1)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  lpt_seq_fsm #(.CNT_W(CNT_W), .SETUP_LD(SETUP_LD), .WIDTH_LD(WIDTH_LD)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .ack_i      (ack_i),
    .zero_i     (tmr_zero),
    .load_o     (tmr_load),
    .load_val_o (tmr_val),
    .accept_o   (accept),
    .ready_o    (ready_o),
    .strobe_no  (strobe_no)
  );

  // data register only loads on an accepted write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_q <= '0;
    else if (accept) data_q <= wdata_i;
  end

  assign pdata_o = data_q;

  lpt_status_pack u_status (
    .fault_i     (fault_i),
    .select_i    (select_i),
    .paper_out_i (paper_out_i),
    .busy_i      (busy_i),
    .ready_i     (ready_o),
    .status_o    (status_o)
  );

  AST_WRITE_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ready_o) |=> (!ready_o && pdata_o == $past(wdata_i))); // R2

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $past(!ready_o)) |-> $stable(pdata_o)); // R8

  AST_STB_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_no |-> !ready_o); // R10

endmodule

// File: tb/lpt_strobe_seq_test.sv
`timescale 1ns/1ps
module lpt_strobe_seq_test;

  localparam longint HZ = 2_500_000;
  localparam int S = int'((HZ * 2000 + 64'd999_999_999) / 64'd1_000_000_000); // 5
  localparam int W = int'((HZ * 1000 + 64'd999_999_999) / 64'd1_000_000_000); // 3 (rounded up)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, ack = 1'b0;
  logic busy = 1'b0, pout = 1'b0, fault = 1'b0, sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] pdata, status;
  logic strobe_n, ready;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lpt_strobe_seq #(.CLK_FREQ_HZ(HZ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wdata), .ack_i(ack),
    .busy_i(busy), .paper_out_i(pout), .fault_i(fault), .select_i(sel),
    .pdata_o(pdata), .strobe_no(strobe_n), .ready_o(ready), .status_o(status)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // one transfer; sampled at negedges after edge t0+k
  task automatic xfer(logic [7:0] d, bit early_ack, bit junk_wr, logic [7:0] prev);
    @(negedge clk);
    chk("R6 ready before write", {7'd0, ready}, 8'd1);
    chk("R8 idle data", pdata, prev);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    for (int k = 0; k < S + W + 2; k++) begin
      chk("R3/R4 strobe timing", {7'd0, strobe_n}, {7'd0, !(k >= S && k < S + W)});
      chk("R6 busy until ack", {7'd0, ready}, 8'd0);
      chk("R5 data hold", pdata, d);
      ack = early_ack && (k == 1 || k == S);          // R7
      wr  = junk_wr && (k == 2 || k == S + W);        // R8
      wdata = ~d;
      @(negedge clk);
      ack = 1'b0; wr = 1'b0;
    end
    chk("R6 wait holds", {7'd0, ready}, 8'd0);
    chk("R10 strobe idle", {7'd0, strobe_n}, 8'd1);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R6 ack rearms", {7'd0, ready}, 8'd1);
    chk("R10 no second strobe", {7'd0, strobe_n}, 8'd1);
    chk("R5 data after ack", pdata, d);
  endtask

  initial begin
    logic [7:0] prev;
    #1;
    @(negedge clk);
    chk("R1 reset strobe", {7'd0, strobe_n}, 8'd1);
    chk("R1 reset ready", {7'd0, ready}, 8'd1);
    chk("R1 reset data", pdata, 8'h00);
    chk("R9 reset status", status, 8'h08);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {6'd0, ready, strobe_n}, 8'd3);

    prev = 8'h00;
    for (int v = 0; v < 256; v++) begin
      xfer(8'(v), (v % 3) == 1, (v % 4) == 2, prev);
      prev = 8'(v);
    end

    // status sweep, idle then busy
    for (int m = 0; m < 16; m++) begin
      {fault, sel, pout, busy} = 4'(m);
      @(negedge clk);
      chk("R9 status idle", status, {4'(m), 1'b1, 3'b000});
    end
    wr = 1'b1; wdata = 8'h5A;
    @(negedge clk);
    wr = 1'b0;
    for (int m = 0; m < 16; m++) begin
      {fault, sel, pout, busy} = 4'(m);
      #0.5;
      chk("R9 status busy", status, {4'(m), 1'b0, 3'b000});
      chk("R2 accepted data", pdata, 8'h5A);
      @(negedge clk);
    end
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R6 final rearm", {7'd0, ready}, 8'd1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule